// File: doc/BRIEF.md
# Event Interrupt Aggregator

This block collects single-cycle event pulses from one peripheral and holds each as a pending flag. It combines the flags into a single active-high interrupt level for a higher-level interrupt controller. Each source has its own bit position. With the default of two sources, bit 0 could carry a "capture trigger" event and bit 1 an "acquisition finished" event.

Software reaches the block through a simple synchronous register port that is one word wide. Each source can be enabled or disabled without disturbing the others. There are two separate write-only command words: one turns sources on and the other turns them off. The current enable set is read back through a read-only word. The pending flags are read from a status word and cleared by writing ones to it. The port carries no data stream. It is a plain command/readback path with no back-pressure: a write takes effect at the clock edge that samples it, and read data appears one cycle after the read strobe.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the enable set is empty, every pending flag is clear, `irq` is 0 and `cfg_rdata` is 0.
- R2: A write to word offset 0x4 enables each source whose bit in `cfg_wdata` is 1. Bits written as 0 leave that source's enable unchanged.
- R3: A write to word offset 0x0 disables each source whose bit in `cfg_wdata` is 1. Bits written as 0 leave that source's enable unchanged.
- R4: A read of word offset 0x8 returns the enable set, with bit i set when source i is enabled. Bits at or above NUM_SRC read 0.
- R5: An event pulse on `src_event[i]` sets pending flag i at that clock edge only if source i is enabled. An event on a disabled source changes nothing.
- R6: A read of word offset 0xC returns the pending flags at bits [NUM_SRC-1:0], with zeros above. Writing 1 to a bit of that word clears the flag, and writing 0 leaves it as it is.
- R7: When an event on an enabled source and a clearing write to the same flag arrive in the same cycle, the flag ends up set.
- R8: `irq` is a registered level. One cycle after any pending flag whose source is enabled exists, `irq` is 1; otherwise it is 0.
- R9: Read data is registered: `cfg_rdata` updates one cycle after `cfg_rd` and holds until the next read. Reads of the write-only words (0x0, 0x4) return 0.
- R10: Disabling a source leaves its pending flag set, but the flag no longer drives `irq`. Re-enabling the source brings `irq` back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NUM_SRC | Single-cycle event pulses, one per source |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Active-high interrupt level |

## Verification
A corrupted enable bit shows up directly on the mask readback one cycle after the read strobe. It also shows up two cycles after an event pulse, because the interrupt level then fails to follow. A stuck or lost pending flag shows on the status readback in the cycle after the read. It also shows on `irq` one edge after the flag should have changed. The directed scenarios drive each path and read back through the register port, so any single bad flag becomes visible within three cycles of the stimulus.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Word selector taken from address bits [3:2]
  typedef enum logic [1:0] {
    WORD_DIS  = 2'd0,
    WORD_ENA  = 2'd1,
    WORD_MASK = 2'd2,
    WORD_STAT = 2'd3
  } word_sel_e;
endpackage

// File: rtl/evt_irq_regdec.sv
module evt_irq_regdec
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] ena_set,
  output logic [NUM_SRC-1:0] ena_clr,
  output logic [NUM_SRC-1:0] stat_clr
);
  word_sel_e sel;
  logic [NUM_SRC-1:0] bits;

  assign sel  = word_sel_e'(addr[3:2]);
  assign bits = wdata[NUM_SRC-1:0];

  always_comb begin
    ena_set  = '0;
    ena_clr  = '0;
    stat_clr = '0;
    if (wr) begin
      case (sel)
        WORD_ENA:  ena_set  = bits;
        WORD_DIS:  ena_clr  = bits;
        WORD_STAT: stat_clr = bits;
        default:   ;
      endcase
    end
  end

  // only one command word can act per cycle (R2, R3, R6)
  a_r6_one_cmd_word: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|ena_set, |ena_clr, |stat_clr}));
endmodule

// File: rtl/evt_irq_enable.sv
module evt_irq_enable #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_bits,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_bits) & ~clr_bits;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    a_r2_enable_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits[i] && !clr_bits[i]) |=> mask[i]);
    a_r3_disable_takes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_bits[i] |=> !mask[i]);
  end
endmodule

// File: rtl/evt_irq_pending.sv
module evt_irq_pending #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                pend[i] <= 1'b0;
      else if (evt[i] && mask[i]) pend[i] <= 1'b1;
      else if (clr[i])           pend[i] <= 1'b0;
    end

    a_r5_set_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(evt[i] && mask[i]));
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && mask[i]) |=> pend[i]);
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !clr[i]) |=> $stable(pend[i]));
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               irq
);
  logic [NUM_SRC-1:0] ena_set, ena_clr, stat_clr, mask, pend;
  logic [DATA_W-1:0]  rd_next;
  logic               unused_bits;

  assign unused_bits = ^{cfg_addr[1:0], cfg_wdata};

  evt_irq_regdec #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .ena_set(ena_set), .ena_clr(ena_clr), .stat_clr(stat_clr)
  );

  evt_irq_enable #(.NUM_SRC(NUM_SRC)) u_ena (
    .clk(clk), .rst_n(rst_n), .set_bits(ena_set), .clr_bits(ena_clr), .mask(mask)
  );

  evt_irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(src_event), .mask(mask), .clr(stat_clr), .pend(pend)
  );

  // readback mux: command words read as zero
  always_comb begin
    rd_next = '0;
    case (word_sel_e'(cfg_addr[3:2]))
      WORD_MASK: rd_next[NUM_SRC-1:0] = mask;
      WORD_STAT: rd_next[NUM_SRC-1:0] = pend;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (cfg_rd) cfg_rdata <= rd_next;
      irq <= |(pend & mask);
    end
  end

  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|pend));
  a_r9_cmd_word_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !cfg_addr[3]) |=> (cfg_rdata == '0));
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));
endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
  localparam int NUM_SRC = 2;
  localparam int DATA_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_SRC-1:0] src_event = '0;
  logic              cfg_wr = 1'b0;
  logic              cfg_rd = 1'b0;
  logic [3:0]        cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] cfg_rdata;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  evt_irq_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(4), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .cfg_wr(cfg_wr),
    .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd_word(input logic [3:0] a, output logic [31:0] d);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] e);
    src_event = e;
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", cfg_rdata, 32'h0);
    rd_word(4'h8, d); check("R1 mask", d, 32'h0);
    rd_word(4'hC, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr_word(4'h4, 32'h1);
    rd_word(4'h8, d); check("R2 enable bit0", d, 32'h1);
    wr_word(4'h4, 32'h0);
    rd_word(4'h8, d); check("R2 zero write no effect", d, 32'h1);
    wr_word(4'h4, 32'hFFFF_FFFF);
    rd_word(4'h8, d); check("R4 upper mask bits zero", d, 32'h3);
    @(negedge clk);
    check("R9 rdata holds", cfg_rdata, 32'h3);
  endtask

  task automatic t_disabled_event;
    logic [31:0] d;
    wr_word(4'h0, 32'h1);
    rd_word(4'h8, d); check("R3 disable bit0", d, 32'h2);
    wr_word(4'h0, 32'h0);
    rd_word(4'h8, d); check("R3 zero write no effect", d, 32'h2);
    wr_word(4'h0, 32'h3);
    rd_word(4'h8, d); check("R3 disable all", d, 32'h0);
    pulse(2'b11);
    @(negedge clk);
    check("R5 disabled no irq", {31'b0, irq}, 32'h0);
    rd_word(4'hC, d); check("R5 disabled no pending", d, 32'h0);
  endtask

  task automatic t_event_irq;
    logic [31:0] d;
    wr_word(4'h4, 32'h2);
    pulse(2'b11);
    check("R8 irq latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq set", {31'b0, irq}, 32'h1);
    rd_word(4'hC, d); check("R5 only enabled pending", d, 32'h2);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr_word(4'hC, 32'h0);
    rd_word(4'hC, d); check("R6 zero write keeps", d, 32'h2);
    wr_word(4'hC, 32'h2);
    check("R8 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
    rd_word(4'hC, d); check("R6 cleared", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    src_event = 2'b10;
    wr_word(4'hC, 32'h2);
    src_event = '0;
    rd_word(4'hC, d); check("R7 event beats clear", d, 32'h2);
  endtask

  task automatic t_mask_drop;
    logic [31:0] d;
    check("R10 irq before disable", {31'b0, irq}, 32'h1);
    wr_word(4'h0, 32'h2);
    @(negedge clk);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    rd_word(4'hC, d); check("R10 pending kept", d, 32'h2);
    wr_word(4'h4, 32'h2);
    @(negedge clk);
    check("R10 irq restored", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_cmd_reads;
    logic [31:0] d;
    rd_word(4'h0, d); check("R9 disable word reads 0", d, 32'h0);
    rd_word(4'h8, d); check("R4 mask readback", d, 32'h2);
    rd_word(4'h4, d); check("R9 enable word reads 0", d, 32'h0);
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_disabled_event();
    t_event_irq();
    t_clear();
    t_collide();
    t_mask_drop();
    t_cmd_reads();
    finish_run();
  end
endmodule